// File: doc/BRIEF.md
# Shared-Memory Ring FIFO Port

This block connects a host command/response stream to a byte ring buffer that sits in an external byte-wide memory. Another processor shares that memory. One side only writes into the ring and the other only reads from it. A ring is located by a base address. The data bytes start at the base, and three control bytes sit directly below it: the size mask, the producer (input) index and the consumer (output) index.

An init command loads all three control bytes into local registers. After that, the block keeps its own copy of the index it owns. It reads the other side's index from memory every time it checks for space or for data. Put commands advance the input index and get commands advance the output index. In each case the new index is written back to memory, so the other processor can see it.

A blocking put or get keeps re-checking until it can proceed. Between two failed checks it lets go of the bus for a few cycles. A non-blocking get answers at once with a no-data flag when the ring is empty.

Top module: `ringport`

## Requirements
- R1: After reset, cmd_ready is 1 and bus_hold, mem_en and rsp_valid are 0. The ring is disabled, so a non-blocking get answers with rsp_nodata=1 and makes no memory access.
- R2: The command encoding on cmd_op is 0 init, 1 put (blocking), 2 get (blocking) and 3 non-blocking get. An init with a nonzero cmd_base performs three reads, in this order: the mask at base-3, the input index at base-2 and the output index at base-1. The values read are kept locally.
- R3: An init with base 0 makes no memory access and disables the ring. While the ring is disabled, every put or get answers at once with rsp_nodata=1 and makes no memory access.
- R4: A put that finds room performs three accesses in order: it reads the output index at base-1, writes the data byte to base+in, then writes (in+1) AND mask to base-2.
- R5: The ring is full when ((in+1) AND mask) equals the output index read from memory. A blocking put then re-reads base-1 and drops bus_hold between attempts, and it completes only once the other side has freed a slot.
- R6: A get that finds data performs three accesses in order: it reads the input index at base-2, reads base+out and returns that byte on rsp_data, then writes (out+1) AND mask to base-1.
- R7: The ring is empty when the input index read from memory equals the local output index. A non-blocking get on an empty ring answers with rsp_nodata=1 after that single read, with no write.
- R8: A blocking get on an empty ring re-reads base-2 until data appears. It then returns that byte.
- R9: An index equal to the mask advances to 0 on the next put or get.
- R10: mem_en is 1 only while bus_hold is 1, and bus_hold is 0 while the response is presented.
- R11: rsp_valid is a one-cycle pulse. cmd_ready is 1 only when no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_op | input | 2 | 0 init, 1 put, 2 get, 3 non-blocking get |
| cmd_base | input | AW (19) | Ring base address (init only) |
| cmd_data | input | DW (8) | Byte to put |
| rsp_valid | output | 1 | Command finished (one cycle) |
| rsp_data | output | DW (8) | Byte taken by a get |
| rsp_nodata | output | 1 | Nothing done: ring empty (non-blocking get) or disabled |
| bus_hold | output | 1 | Shared memory bus requested |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (19) | Memory byte address |
| mem_wdata | output | DW (8) | Write data |
| mem_rdata | input | DW (8) | Read data, valid the cycle after a read |

## Verification
The bench emulates the other processor by changing index bytes in memory between commands, and it compares the exact order of addresses and data of each memory access against the requirements.

The patterns cover:
- Rings that have room or data, which show that the correct index is re-read and the correct one is written back.
- Indices that run up to the mask, which separate correct wrapping from a plain increment.
- A full ring and an empty ring that are released only after a delay. These separate real polling from a single check.
- A ring that was never initialised and one initialised with base 0. These show that no bus access takes place.

// File: rtl/ringport_pkg.sv
package ringport_pkg;
    typedef enum logic [1:0] {
        OP_INIT   = 2'd0,
        OP_PUT    = 2'd1,
        OP_GET    = 2'd2,
        OP_TRYGET = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_MASK, PH_IN, PH_OUT, PH_CHK, PH_DATA, PH_IDX
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_RDW, ST_WR, ST_GAP, ST_RESP
    } state_e;
endpackage

// File: rtl/ringport_agen.sv
module ringport_agen
    import ringport_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  phase_e          ph,
    input  logic            is_put,
    input  logic [AW-1:0]   base,
    input  logic [DW-1:0]   in_idx,
    input  logic [DW-1:0]   out_idx,
    input  logic [DW-1:0]   data,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   wdata
);
    localparam int PADW = AW - DW;

    logic [DW-1:0] own_idx;
    logic [AW-1:0] slot_addr;

    assign own_idx   = is_put ? in_idx : out_idx;
    assign slot_addr = base + {{PADW{1'b0}}, own_idx};

    always_comb begin
        unique case (ph)
            PH_MASK: addr = base - AW'(3);
            PH_IN:   addr = base - AW'(2);
            PH_OUT:  addr = base - AW'(1);
            PH_CHK:  addr = is_put ? base - AW'(1) : base - AW'(2);
            PH_DATA: addr = slot_addr;
            default: addr = is_put ? base - AW'(2) : base - AW'(1);
        endcase
        wdata = (ph == PH_DATA) ? data : own_idx;
    end
endmodule

// File: rtl/ringport_cond.sv
module ringport_cond #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] in_idx,
    input  logic [DW-1:0] out_idx,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] peer_idx,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] in_next;

    assign in_next = (in_idx + DW'(1)) & mask;
    assign full    = (in_next == peer_idx);
    assign empty   = (peer_idx == out_idx);
endmodule

// File: rtl/ringport.sv
module ringport
    import ringport_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int GAP_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_base,
    input  logic [DW-1:0] cmd_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_nodata,
    output logic          bus_hold,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        state_e        st;
        phase_e        ph;
        op_e           op;
        logic [AW-1:0] base;
        logic [DW-1:0] mask;
        logic [DW-1:0] in_idx;
        logic [DW-1:0] out_idx;
        logic [DW-1:0] data;
        logic          nodata;
        logic [GW-1:0] gap;
    } ctx_t;

    ctx_t ctx_q, ctx_d;
    logic is_full, is_empty;
    logic is_put_q;

    assign is_put_q = (ctx_q.op == OP_PUT);

    ringport_agen #(.AW(AW), .DW(DW)) i_agen (
        .ph      (ctx_q.ph),
        .is_put  (is_put_q),
        .base    (ctx_q.base),
        .in_idx  (ctx_q.in_idx),
        .out_idx (ctx_q.out_idx),
        .data    (ctx_q.data),
        .addr    (mem_addr),
        .wdata   (mem_wdata)
    );

    ringport_cond #(.DW(DW)) i_cond (
        .in_idx   (ctx_q.in_idx),
        .out_idx  (ctx_q.out_idx),
        .mask     (ctx_q.mask),
        .peer_idx (mem_rdata),
        .full     (is_full),
        .empty    (is_empty)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctx_d.op     = op_e'(cmd_op);
                    ctx_d.data   = cmd_data;
                    ctx_d.nodata = 1'b0;
                    if (op_e'(cmd_op) == OP_INIT) begin
                        ctx_d.base = cmd_base;
                        if (cmd_base == '0) begin
                            ctx_d.mask    = '0;
                            ctx_d.in_idx  = '0;
                            ctx_d.out_idx = '0;
                            ctx_d.st      = ST_RESP;
                        end else begin
                            ctx_d.ph = PH_MASK;
                            ctx_d.st = ST_RD;
                        end
                    end else if (ctx_q.base == '0) begin
                        ctx_d.nodata = 1'b1;
                        ctx_d.st     = ST_RESP;
                    end else begin
                        ctx_d.ph = PH_CHK;
                        ctx_d.st = ST_RD;
                    end
                end
            end
            ST_RD: ctx_d.st = ST_RDW;
            ST_RDW: begin
                unique case (ctx_q.ph)
                    PH_MASK: begin
                        ctx_d.mask = mem_rdata;
                        ctx_d.ph   = PH_IN;
                        ctx_d.st   = ST_RD;
                    end
                    PH_IN: begin
                        ctx_d.in_idx = mem_rdata;
                        ctx_d.ph     = PH_OUT;
                        ctx_d.st     = ST_RD;
                    end
                    PH_OUT: begin
                        ctx_d.out_idx = mem_rdata;
                        ctx_d.st      = ST_RESP;
                    end
                    PH_CHK: begin
                        if (is_put_q) begin
                            if (is_full) begin
                                ctx_d.gap = '0;
                                ctx_d.st  = ST_GAP;
                            end else begin
                                ctx_d.ph = PH_DATA;
                                ctx_d.st = ST_WR;
                            end
                        end else if (is_empty) begin
                            if (ctx_q.op == OP_TRYGET) begin
                                ctx_d.nodata = 1'b1;
                                ctx_d.st     = ST_RESP;
                            end else begin
                                ctx_d.gap = '0;
                                ctx_d.st  = ST_GAP;
                            end
                        end else begin
                            ctx_d.ph = PH_DATA;
                            ctx_d.st = ST_RD;
                        end
                    end
                    default: begin
                        ctx_d.data    = mem_rdata;
                        ctx_d.out_idx = (ctx_q.out_idx + DW'(1)) & ctx_q.mask;
                        ctx_d.ph      = PH_IDX;
                        ctx_d.st      = ST_WR;
                    end
                endcase
            end
            ST_WR: begin
                if (ctx_q.ph == PH_DATA) begin
                    ctx_d.in_idx = (ctx_q.in_idx + DW'(1)) & ctx_q.mask;
                    ctx_d.ph     = PH_IDX;
                end else begin
                    ctx_d.st = ST_RESP;
                end
            end
            ST_GAP: begin
                if (ctx_q.gap == GW'(GAP_CYCLES - 1)) begin
                    ctx_d.ph = PH_CHK;
                    ctx_d.st = ST_RD;
                end else begin
                    ctx_d.gap = ctx_q.gap + GW'(1);
                end
            end
            default: begin
                ctx_d.nodata = 1'b0;
                ctx_d.st     = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, ph: PH_MASK, op: OP_INIT, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign cmd_ready  = (ctx_q.st == ST_IDLE);
    assign rsp_valid  = (ctx_q.st == ST_RESP);
    assign rsp_data   = ctx_q.data;
    assign rsp_nodata = ctx_q.nodata;
    assign bus_hold   = (ctx_q.st == ST_RD) || (ctx_q.st == ST_RDW) || (ctx_q.st == ST_WR);
    assign mem_en     = (ctx_q.st == ST_RD) || (ctx_q.st == ST_WR);
    assign mem_we     = (ctx_q.st == ST_WR);
endmodule

// File: rtl/ringport_chk.sv
module ringport_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic rsp_valid,
    input logic rsp_nodata,
    input logic bus_hold,
    input logic mem_en
);
    AST_EN_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_hold); // R10

    AST_RSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_hold); // R10

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!bus_hold && !rsp_valid)); // R11

    AST_NODATA_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nodata |-> rsp_valid); // R7

    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> cmd_ready); // R11
endmodule

bind ringport ringport_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_nodata (rsp_nodata),
    .bus_hold   (bus_hold),
    .mem_en     (mem_en)
);

// File: tb/test_ringport.sv
`timescale 1ns/1ps
module test_ringport;
    localparam int AW = 19;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_base = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_nodata;
    logic          bus_hold;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    always #2.5 clk = ~clk;

    ringport #(.AW(AW), .DW(DW), .GAP_CYCLES(2)) i_ringport (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nodata(rsp_nodata),
        .bus_hold(bus_hold), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // shared memory model plus bench-side pokes (the other processor)
    logic [7:0] mem [0:1023];
    logic       poke_en = 1'b0;
    logic [9:0] poke_addr = '0;
    logic [7:0] poke_data = '0;
    logic [7:0] rd_q = '0;
    assign mem_rdata = rd_q;

    int         nacc = 0;
    int         nohold = 0;
    int         falls = 0;
    logic       hold_prev = 1'b0;
    logic [9:0] log_a [0:63];
    logic       log_w [0:63];
    logic [7:0] log_d [0:63];

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_en && !mem_we) rd_q <= mem[mem_addr[9:0]];
        if (poke_en) mem[poke_addr] <= poke_data;
        if (mem_en) begin
            log_a[nacc % 64] <= mem_addr[9:0];
            log_w[nacc % 64] <= mem_we;
            log_d[nacc % 64] <= mem_wdata;
            nacc <= nacc + 1;
            if (!bus_hold) nohold <= nohold + 1;
        end
        hold_prev <= bus_hold;
        if (hold_prev && !bus_hold) falls <= falls + 1;
    end

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = 10'(a); poke_data = 8'(d);
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic issue(input int op, input int base, input int d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_base = AW'(base); cmd_data = 8'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int lim, output bit got, output int d, output bit nd);
        got = 1'b0; d = 0; nd = 1'b0;
        for (int k = 0; k < lim; k++) begin
            if (rsp_valid) begin
                got = 1'b1; d = int'(rsp_data); nd = rsp_nodata;
                @(negedge clk);
                chk(!rsp_valid && cmd_ready, "R11 pulse/ready", int'(rsp_valid), 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run(input int op, input int base, input int din, input string req,
                       output int d, output bit nd);
        bit got;
        issue(op, base, din);
        wait_rsp(200, got, d, nd);
        chk(got, req, int'(got), 1);
    endtask

    task automatic acc(input int st, input int k, input int a, input bit w, input int d,
                       input string req);
        int i;
        i = (st + k) % 64;
        chk(log_a[i] == 10'(a) && log_w[i] == w && (!w || log_d[i] == 8'(d)),
            req, int'(log_a[i]), a);
    endtask

    task automatic t_reset();
        int d; bit nd; int s;
        chk(cmd_ready && !bus_hold && !mem_en && !rsp_valid, "R1 reset outputs",
            int'({cmd_ready, bus_hold, mem_en, rsp_valid}), 8);
        s = nacc;
        run(3, 0, 0, "R1 tryget before init", d, nd);
        chk(nd, "R1 nodata before init", int'(nd), 1);
        chk(nacc == s, "R1 no access before init", nacc - s, 0);
    endtask

    task automatic t_init();
        int d; bit nd; int s;
        poke(12'h0FD, 8'h07); poke(12'h0FE, 3); poke(12'h0FF, 3);
        s = nacc;
        run(0, 12'h100, 0, "R2 init response", d, nd);
        chk(nacc - s == 3, "R2 init access count", nacc - s, 3);
        acc(s, 0, 12'h0FD, 1'b0, 0, "R2 mask read at base-3");
        acc(s, 1, 12'h0FE, 1'b0, 0, "R2 in read at base-2");
        acc(s, 2, 12'h0FF, 1'b0, 0, "R2 out read at base-1");
        s = nacc;
        run(3, 0, 0, "R7 tryget empty", d, nd);
        chk(nd, "R7 nodata when empty", int'(nd), 1);
        chk(nacc - s == 1, "R7 single read, no write", nacc - s, 1);
        acc(s, 0, 12'h0FE, 1'b0, 0, "R7 reads base-2");
    endtask

    task automatic t_put_get();
        int d; bit nd; int s;
        s = nacc;
        run(1, 0, 8'hA5, "R4 put response", d, nd);
        chk(nacc - s == 3, "R4 put access count", nacc - s, 3);
        acc(s, 0, 12'h0FF, 1'b0, 0, "R4 read out at base-1");
        acc(s, 1, 12'h103, 1'b1, 8'hA5, "R4 data write base+in");
        acc(s, 2, 12'h0FE, 1'b1, 4, "R4 index write base-2");
        chk(mem[12'h0FE] == 8'd4, "R4 mem in index", int'(mem[12'h0FE]), 4);
        s = nacc;
        run(2, 0, 0, "R6 get response", d, nd);
        chk(d == 8'hA5 && !nd, "R6 get data", d, 8'hA5);
        acc(s, 0, 12'h0FE, 1'b0, 0, "R6 read in at base-2");
        acc(s, 1, 12'h103, 1'b0, 0, "R6 read base+out");
        acc(s, 2, 12'h0FF, 1'b1, 4, "R6 out write base-1");
        chk(!bus_hold, "R10 idle release", int'(bus_hold), 0);
    endtask

    task automatic t_wrap();
        int d; bit nd;
        for (int k = 0; k < 4; k++) run(1, 0, 8'h11 * (k + 1), "R9 put", d, nd);
        chk(mem[12'h0FE] == 8'd0, "R9 in wraps to 0", int'(mem[12'h0FE]), 0);
        chk(mem[12'h107] == 8'h44, "R9 slot at mask", int'(mem[12'h107]), 8'h44);
        for (int k = 0; k < 4; k++) begin
            run(2, 0, 0, "R9 get", d, nd);
            chk(d == 8'h11 * (k + 1), "R9 get data order", d, 8'h11 * (k + 1));
        end
        chk(mem[12'h0FF] == 8'd0, "R9 out wraps to 0", int'(mem[12'h0FF]), 0);
    endtask

    task automatic t_full_poll();
        int d; bit nd; bit got; int f0; int s; int reads;
        poke(12'h0FF, 1);
        f0 = falls; s = nacc;
        issue(1, 0, 8'h5A);
        got = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (rsp_valid) got = 1'b1;
        end
        chk(!got, "R5 put waits while full", int'(got), 0);
        reads = 0;
        for (int k = 0; k < nacc - s && k < 64; k++)
            if (log_a[(s + k) % 64] == 10'h0FF && !log_w[(s + k) % 64]) reads++;
        chk(reads >= 2, "R5 re-reads base-1", reads, 2);
        chk(falls - f0 >= 2, "R5 bus released between polls", falls - f0, 2);
        poke(12'h0FF, 2);
        wait_rsp(100, got, d, nd);
        chk(got && !nd, "R5 put completes after space", int'(got), 1);
        chk(mem[12'h100] == 8'h5A, "R5 data written", int'(mem[12'h100]), 8'h5A);
        chk(mem[12'h0FE] == 8'd1, "R5 in index written", int'(mem[12'h0FE]), 1);
    endtask

    task automatic t_empty_poll();
        int d; bit nd; bit got;
        run(2, 0, 0, "R6 get after poll put", d, nd);
        chk(d == 8'h5A, "R6 data", d, 8'h5A);
        issue(2, 0, 0);
        got = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (rsp_valid) got = 1'b1;
        end
        chk(!got, "R8 get waits while empty", int'(got), 0);
        poke(12'h101, 8'h3C);
        poke(12'h0FE, 2);
        wait_rsp(100, got, d, nd);
        chk(got && d == 8'h3C && !nd, "R8 data after producer", d, 8'h3C);
        chk(mem[12'h0FF] == 8'd2, "R8 out index written", int'(mem[12'h0FF]), 2);
    endtask

    task automatic t_disable();
        int d; bit nd; int s;
        s = nacc;
        run(0, 0, 0, "R3 init base 0", d, nd);
        run(1, 0, 8'h77, "R3 put disabled", d, nd);
        chk(nd, "R3 put nodata", int'(nd), 1);
        run(2, 0, 0, "R3 get disabled", d, nd);
        chk(nd, "R3 get nodata", int'(nd), 1);
        chk(nacc == s, "R3 no access when disabled", nacc - s, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_put_get();
        t_wrap();
        t_full_poll();
        t_empty_poll();
        t_disable();
        chk(nohold == 0, "R10 access outside bus hold", nohold, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule